// File: doc/BRIEF.md
# FIFO Bus-Request Threshold Logic

This block watches the fill level of a 64-byte transmit FIFO and a receive FIFO. Both FIFOs are organised in 32-bit dwords. It tells the bus master when each FIFO needs service. The transmit side asks for a memory fetch once the FIFO has drained down to a programmed low-water mark. The receive side asks for a drain to memory once the FIFO has filled up to a programmed high-water mark.

The two water marks are set by compact codes, not by byte counts. The transmit code is the mark in dwords. The receive code counts down from full capacity. Its step doubles when the larger, 128-byte receive FIFO is selected. Both codes are written through a single write strobe and are held in registers.

The FIFO storage and the bus master sit outside this block. There is no data stream through it: every pin is a plain level signal, so no back-pressure applies.

Top module: `fifo_bus_req`

## Requirements
- R1: After reset the transmit code is 0 and the receive code is 8, which gives a receive mark of 8 dwords with the small FIFO and 16 dwords with the large one.
- R2: A write with `cfg_wr` high loads both codes at the clock edge, and the new codes govern the request outputs from the next cycle on. With `cfg_wr` low, the code inputs have no effect on the outputs.
- R3: For a transmit code t (0 to 7), `tx_req` is high exactly when `tx_level` is at most t dwords and `tx_eof_fetched` is low.
- R4: `tx_req` is low whenever `tx_eof_fetched` is high, at any level.
- R5: With `rx_large` = 0 (64-byte FIFO), the receive mark for code c is 16 − c dwords, and `rx_req` is high when `rx_level` is at or above that mark.
- R6: With `rx_large` = 1 (128-byte FIFO), the receive mark for code c is 2 × (16 − c) dwords, applied in the same way.
- R7: `rx_req` is high whenever `rx_eof_present` is high, even below the mark.
- R8: `rx_large` and the level and end-of-frame inputs act in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load strobe for both threshold codes |
| cfg_tx_code | input | 3 | Transmit mark code, in dwords |
| cfg_rx_code | input | 4 | Receive mark code, counted down from full |
| rx_large | input | 1 | 0 selects the 64-byte receive FIFO, 1 selects the 128-byte one |
| tx_level | input | 5 | Transmit FIFO occupancy in dwords (0 to 16) |
| tx_eof_fetched | input | 1 | Last dword of the current frame is already in the transmit FIFO |
| rx_level | input | 6 | Receive FIFO occupancy in dwords (0 to 32) |
| rx_eof_present | input | 1 | A frame end is held in the receive FIFO |
| tx_req | output | 1 | Request a bus fetch into the transmit FIFO |
| rx_req | output | 1 | Request a bus drain of the receive FIFO |

## Verification
A corrupted code register shows up at the ports within one cycle of the next level sweep. It appears as a request edge at the wrong occupancy, and the offset is exactly the error in dwords. A wrong receive step appears only in one size mode, so both sizes are swept against every code. A lost end-of-frame override appears only below the mark, so every level from empty upward is checked with the override both high and low.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  typedef enum logic {
    RX_SMALL = 1'b0,
    RX_LARGE = 1'b1
  } rx_size_e;

  localparam int TX_CODE_RST = 0;
  localparam int RX_CODE_RST = 8;
endpackage

// File: rtl/fbr_cfg_reg.sv
module fbr_cfg_reg #(
  parameter int TXC_W = 3,
  parameter int RXC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [TXC_W-1:0] tx_code_in,
  input  logic [RXC_W-1:0] rx_code_in,
  output logic [TXC_W-1:0] tx_code,
  output logic [RXC_W-1:0] rx_code
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_code <= TXC_W'(fbr_pkg::TX_CODE_RST);
      rx_code <= RXC_W'(fbr_pkg::RX_CODE_RST);
    end else if (wr) begin
      tx_code <= tx_code_in;
      rx_code <= rx_code_in;
    end
  end

  assert_reset_codes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (tx_code == TXC_W'(fbr_pkg::TX_CODE_RST)) &&
                      (rx_code == RXC_W'(fbr_pkg::RX_CODE_RST)));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (tx_code == $past(tx_code_in)) && (rx_code == $past(rx_code_in)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(tx_code) && $stable(rx_code));
endmodule

// File: rtl/fbr_tx_req.sv
module fbr_tx_req #(
  parameter int TXC_W    = 3,
  parameter int TX_LVL_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TXC_W-1:0]    code,
  input  logic [TX_LVL_W-1:0] level,
  input  logic                eof_fetched,
  output logic                req
);
  localparam int MAX_MARK = (2 ** TXC_W) - 1;

  logic [TX_LVL_W-1:0] mark;

  always_comb begin
    mark = TX_LVL_W'(code);
    req  = (level <= mark) && !eof_fetched;
  end

  assert_eof_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eof_fetched |-> !req);

  assert_deep_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(level) > MAX_MARK) |-> !req);

  assert_empty_asks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && !eof_fetched) |-> req);
endmodule

// File: rtl/fbr_rx_req.sv
module fbr_rx_req #(
  parameter int RXC_W       = 4,
  parameter int RX_SMALL_DW = 16,
  parameter int RX_LVL_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RXC_W-1:0]    code,
  input  fbr_pkg::rx_size_e   size,
  input  logic [RX_LVL_W-1:0] level,
  input  logic                eof_present,
  output logic                req
);
  localparam int NCODES = 2 ** RXC_W;
  localparam int STEP   = RX_SMALL_DW / NCODES;

  logic [RX_LVL_W-1:0] base_mark;
  logic [RX_LVL_W-1:0] mark;
  logic [RX_LVL_W-1:0] cap;

  always_comb begin
    base_mark = RX_LVL_W'(STEP * (NCODES - int'(code)));
    mark      = (size == fbr_pkg::RX_LARGE) ? (base_mark << 1) : base_mark;
    cap       = (size == fbr_pkg::RX_LARGE) ? RX_LVL_W'(2 * RX_SMALL_DW)
                                            : RX_LVL_W'(RX_SMALL_DW);
    req       = (level >= mark) || eof_present;
  end

  assert_eof_forces_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eof_present |-> req);

  assert_empty_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && !eof_present) |-> !req);

  assert_full_drains_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= cap) |-> req);
endmodule

// File: rtl/fifo_bus_req.sv
module fifo_bus_req #(
  parameter int TXC_W       = 3,
  parameter int RXC_W       = 4,
  parameter int TX_CAP_DW   = 16,
  parameter int RX_SMALL_DW = 16,
  localparam int TX_LVL_W   = $clog2(TX_CAP_DW + 1),
  localparam int RX_LVL_W   = $clog2(2 * RX_SMALL_DW + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [TXC_W-1:0]    cfg_tx_code,
  input  logic [RXC_W-1:0]    cfg_rx_code,
  input  logic                rx_large,
  input  logic [TX_LVL_W-1:0] tx_level,
  input  logic                tx_eof_fetched,
  input  logic [RX_LVL_W-1:0] rx_level,
  input  logic                rx_eof_present,
  output logic                tx_req,
  output logic                rx_req
);
  logic [TXC_W-1:0]  tx_code_q;
  logic [RXC_W-1:0]  rx_code_q;
  fbr_pkg::rx_size_e rx_size;

  assign rx_size = fbr_pkg::rx_size_e'(rx_large);

  fbr_cfg_reg #(.TXC_W(TXC_W), .RXC_W(RXC_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (cfg_wr),
    .tx_code_in (cfg_tx_code),
    .rx_code_in (cfg_rx_code),
    .tx_code    (tx_code_q),
    .rx_code    (rx_code_q)
  );

  fbr_tx_req #(.TXC_W(TXC_W), .TX_LVL_W(TX_LVL_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .code        (tx_code_q),
    .level       (tx_level),
    .eof_fetched (tx_eof_fetched),
    .req         (tx_req)
  );

  fbr_rx_req #(.RXC_W(RXC_W), .RX_SMALL_DW(RX_SMALL_DW), .RX_LVL_W(RX_LVL_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .code        (rx_code_q),
    .size        (rx_size),
    .level       (rx_level),
    .eof_present (rx_eof_present),
    .req         (rx_req)
  );
endmodule

// File: tb/fifo_bus_req_test.sv
module fifo_bus_req_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr;
  logic [2:0] cfg_tx_code;
  logic [3:0] cfg_rx_code;
  logic       rx_large;
  logic [4:0] tx_level;
  logic       tx_eof_fetched;
  logic [5:0] rx_level;
  logic       rx_eof_present;
  logic       tx_req;
  logic       rx_req;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  fifo_bus_req uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
    .cfg_tx_code(cfg_tx_code), .cfg_rx_code(cfg_rx_code),
    .rx_large(rx_large), .tx_level(tx_level), .tx_eof_fetched(tx_eof_fetched),
    .rx_level(rx_level), .rx_eof_present(rx_eof_present),
    .tx_req(tx_req), .rx_req(rx_req)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic tx_exp(int code, int lvl, bit eof);
    return (lvl <= code) && !eof;
  endfunction

  function automatic logic rx_exp(int code, bit big, int lvl, bit eof);
    int mark = (16 - code) * (big ? 2 : 1);
    return (lvl >= mark) || eof;
  endfunction

  task automatic write_codes(input int t, input int r);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_tx_code = 3'(t); cfg_rx_code = 4'(r);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic sweep_tx(input int code, input string tag);
    for (int e = 0; e < 2; e++) begin
      for (int l = 0; l <= 16; l++) begin
        tx_level = 5'(l); tx_eof_fetched = e[0];
        #1;
        check(e ? "R4" : tag, tx_req, tx_exp(code, l, e[0]));
      end
    end
    tx_eof_fetched = 1'b0;
  endtask

  task automatic sweep_rx(input int code, input string tag);
    for (int b = 0; b < 2; b++) begin
      for (int e = 0; e < 2; e++) begin
        for (int l = 0; l <= 32; l++) begin
          rx_large = b[0]; rx_level = 6'(l); rx_eof_present = e[0];
          #1;
          check(e ? "R7" : (b ? "R6" : tag), rx_req, rx_exp(code, b[0], l, e[0]));
        end
      end
    end
    rx_eof_present = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_tx_code = 3'd5; cfg_rx_code = 4'd3;
    rx_large = 1'b0; tx_level = '0; tx_eof_fetched = 1'b0;
    rx_level = '0; rx_eof_present = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset codes (tx 0, rx 8) seen through the request outputs
    sweep_tx(0, "R1");
    sweep_rx(8, "R1");

    // R2: code inputs ignored while cfg_wr is low
    cfg_tx_code = 3'd7; cfg_rx_code = 4'd15;
    repeat (2) @(negedge clk);
    tx_level = 5'd3; #1; check("R2", tx_req, 1'b0);
    rx_large = 1'b0; rx_level = 6'd4; #1; check("R2", rx_req, 1'b0);

    // R2: a write takes effect from the next cycle
    @(negedge clk);
    cfg_wr = 1'b1; cfg_tx_code = 3'd4; cfg_rx_code = 4'd12;
    tx_level = 5'd4; rx_level = 6'd4; #1;
    check("R2", tx_req, 1'b0);
    check("R2", rx_req, 1'b0);
    @(negedge clk);
    cfg_wr = 1'b0; #1;
    check("R2", tx_req, 1'b1);
    check("R2", rx_req, 1'b1);

    // R3, R5, R6, R8: full sweeps over every code pair
    for (int c = 0; c < 16; c++) begin
      write_codes(c % 8, c);
      sweep_tx(c % 8, "R3");
      sweep_rx(c, "R5");
    end

    // R8: size select acts in the same cycle
    write_codes(0, 10);
    rx_level = 6'd8; rx_large = 1'b0; #1; check("R8", rx_req, 1'b1);
    rx_large = 1'b1; #1; check("R8", rx_req, 1'b0);
    rx_large = 1'b0; #1; check("R8", rx_req, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule